// File: doc/BRIEF.md
# Programmable System Clock Divider

This block turns a source clock into a slower system timing reference. The reference is a one-cycle clock-enable pulse every N source cycles, together with a registered divided clock. A source-select input tells the block which kind of clock is feeding it. One kind is a fast clock from a frequency synthesizer. The other is a slower plain reference. The choice of the source clock itself is made upstream. This block only applies the divisor rules that belong to the selected source.

Software sets a 4-bit divide field and a divider-enable bit through a single-cycle write port. The read port always shows the divisor that is actually in effect. With the synthesizer source selected, the divider is always in use and small divisors are raised to a floor of /4. Ratio and source changes are applied only when the running count wraps. A period that is already in progress therefore always completes at its old length.

Top module: `sysdiv_top`

## Requirements
- R1: While the divider is in use, the effective divide field value v gives a period of N = v + 1 source cycles between `sys_ce` pulses, so `sys_ce` is never low for more than 15 cycles in a row.
- R2: During and after reset, the stored divide field is 0xF and the enable bit is 0, so `rd_data` reads 0x0F. While reset is held, `sys_ce` is high and `div_clk` is low.
- R3: A stored field of 0x0 never gives division by 1. It is treated as the smallest legal value for the current source: 1 for the plain reference and 3 for the synthesizer.
- R4: With `src_ref` = 0 (synthesizer source), stored fields 0x0 to 0x2 act as 0x3, giving /4, and `rd_data[3:0]` returns 3.
- R5: With `src_ref` = 1 (plain reference), stored fields 0x1 and 0x2 are used as written, giving /2 and /3.
- R6: With `src_ref` = 1 and the enable bit at 0, the divider is bypassed: `sys_ce` is high on every cycle and `div_clk` stays low. With the enable bit at 1, the output is divided.
- R7: With `src_ref` = 0, the divider is in use whatever the enable bit holds. `rd_data[5]` still returns the stored enable bit.
- R8: In each period of N cycles, `div_clk` is high for the first floor(N/2) cycles and low for the rest. It is never high in the cycle where `sys_ce` is high, and it rises only in the cycle after a `sys_ce` pulse.
- R9: A new divide field, enable bit or source takes effect only at the edge that ends the current period. The period in progress completes with its old length.
- R10: The register layout is as follows. Bits [3:0] hold the divide field (readback shows the effective value). Bit 4 is unused: writes to it are ignored and it reads as 0. Bit 5 is the divider-enable bit. Readback is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_ref | input | 1 | Source select: 1 = plain reference, 0 = synthesizer |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 6 | Register write value |
| rd_data | output | 6 | Effective divide field, 0 pad bit, stored enable bit |
| sys_ce | output | 1 | One-cycle enable at the end of each division period |
| div_clk | output | 1 | Registered divided clock, high for floor(N/2) cycles |

## Verification
The assertions assume that `src_ref`, `wr_en` and `wr_data` are synchronous to `clk`. They also assume that `clk` really is the source named by `src_ref`, since the period bounds only make sense on that clock. The stimulus drives every input on falling edges only. It changes `src_ref` only in the cycle right after a write has landed on a period boundary. This keeps the setting for the period in progress unambiguous, so the bench can predict both the old and the new period length.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;
  typedef enum logic {
    SRC_SYNTH = 1'b0,
    SRC_PLAIN = 1'b1
  } src_e;

  localparam int SYNTH_FLOOR = 3;
  localparam int PLAIN_FLOOR = 1;
endpackage

// File: rtl/sysdiv_rst_sync.sv
module sysdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= 2'b00;
    end else begin
      pipe_q <= {pipe_q[0], 1'b1};
    end
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/sysdiv_cfg.sv
module sysdiv_cfg
  import sysdiv_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int SYN_FLOOR = SYNTH_FLOOR,
  parameter int PLN_FLOOR = PLAIN_FLOOR,
  localparam int REG_W    = DIV_W + 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             src_ref,
  output logic [DIV_W-1:0] eff_div,
  output logic             use_div,
  output logic [REG_W-1:0] rd_data
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             en_q, en_d;
  logic [DIV_W-1:0] floor_v;
  logic             unused_pad;

  assign unused_pad = wr_data[DIV_W];

  // next-state: write strobe acts as the clock enable
  always_comb begin
    div_d = div_q;
    en_d  = en_q;
    if (wr_en) begin
      div_d = wr_data[DIV_W-1:0];
      en_d  = wr_data[REG_W-1];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      div_q <= '1;
      en_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      en_q  <= en_d;
    end
  end

  // clamp to the floor of the current source; synthesizer forces the divider
  always_comb begin
    floor_v = (src_ref == SRC_PLAIN) ? DIV_W'(PLN_FLOOR) : DIV_W'(SYN_FLOOR);
    eff_div = (div_q < floor_v) ? floor_v : div_q;
    use_div = en_q | (src_ref == SRC_SYNTH);
    rd_data = {en_q, 1'b0, eff_div};
  end
endmodule

// File: rtl/sysdiv_count.sv
module sysdiv_count #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [DIV_W-1:0] eff_div,
  input  logic             use_div,
  output logic             sys_ce,
  output logic             div_clk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             use_q, use_d;
  logic             dclk_q, dclk_d;
  logic             wrap;
  logic [DIV_W:0]   half_d;

  assign wrap = ~use_q | (cnt_q == act_q);

  // settings are sampled only on the wrap edge
  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      act_d = eff_div;
      use_d = use_div;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
      act_d = act_q;
      use_d = use_q;
    end
    half_d = ({1'b0, act_d} + (DIV_W+1)'(1)) >> 1;
    dclk_d = use_d & ({1'b0, cnt_d} < half_d);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      act_q  <= '1;
      use_q  <= 1'b0;
      dclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      use_q  <= use_d;
      dclk_q <= dclk_d;
    end
  end

  assign sys_ce  = wrap;
  assign div_clk = dclk_q;
endmodule

// File: rtl/sysdiv_top.sv
module sysdiv_top #(
  parameter int DIV_W    = 4,
  localparam int REG_W   = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_ref,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sys_ce,
  output logic             div_clk
);
  logic             srst_n;
  logic [DIV_W-1:0] eff_div;
  logic             use_div;

  sysdiv_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sysdiv_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .src_ref (src_ref),
    .eff_div (eff_div),
    .use_div (use_div),
    .rd_data (rd_data)
  );

  sysdiv_count #(.DIV_W(DIV_W)) u_cnt (
    .clk     (clk),
    .srst_n  (srst_n),
    .eff_div (eff_div),
    .use_div (use_div),
    .sys_ce  (sys_ce),
    .div_clk (div_clk)
  );
endmodule

// File: rtl/sysdiv_chk.sv
module sysdiv_chk #(
  parameter int DIV_W   = 4,
  localparam int REG_W  = DIV_W + 2
) (
  input logic             clk,
  input logic             srst_n,
  input logic             src_ref,
  input logic [REG_W-1:0] rd_data,
  input logic             sys_ce,
  input logic             div_clk
);
  logic [DIV_W:0] gap_q;

  // counts consecutive cycles with sys_ce low
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      gap_q <= '0;
    end else if (sys_ce) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + (DIV_W+1)'(1);
    end
  end

  assert_gap_bound_R1: assert property (@(posedge clk) disable iff (!srst_n)
    gap_q < (DIV_W+1)'(2**DIV_W));

  assert_never_unity_R3: assert property (@(posedge clk) disable iff (!srst_n)
    rd_data[DIV_W-1:0] != '0);

  assert_synth_floor_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !src_ref |-> rd_data[DIV_W-1:0] >= DIV_W'(3));

  assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!srst_n)
    rd_data[DIV_W] == 1'b0);

  assert_ce_outside_high_R8: assert property (@(posedge clk) disable iff (!srst_n)
    div_clk |-> !sys_ce);

  assert_rise_after_ce_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(div_clk) |-> $past(sys_ce));
endmodule

bind sysdiv_top sysdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .src_ref (src_ref),
  .rd_data (rd_data),
  .sys_ce  (sys_ce),
  .div_clk (div_clk)
);

// File: tb/sysdiv_top_tb.sv
module sysdiv_top_tb;
  logic       clk;
  logic       rst_n;
  logic       src_ref;
  logic       wr_en;
  logic [5:0] wr_data;
  logic [5:0] rd_data;
  logic       sys_ce;
  logic       div_clk;
  int         checks;
  int         fails;
  bit         done;

  sysdiv_top u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_ref (src_ref),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .sys_ce  (sys_ce),
    .div_clk (div_clk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_val(input bit byp, input int f);
    int mn;
    mn = byp ? 1 : 3;
    return (f < mn) ? mn : f;
  endfunction

  function automatic int period(input bit byp, input bit en, input int f);
    if (byp && !en) return 1;
    return eff_val(byp, f) + 1;
  endfunction

  // counts cycles from the current falling edge up to and including the next sys_ce
  task automatic measure(output int n, output int hi);
    n  = 0;
    hi = 0;
    forever begin
      n++;
      if (div_clk) hi++;
      if (sys_ce || n >= 40) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev_n;
    int n;
    int hi;
    string tag;
    checks  = 0;
    fails   = 0;
    done    = 0;
    rst_n   = 1'b0;
    src_ref = 1'b1;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset readback", int'(rd_data), 'h0F);
    chk("R2 reset sys_ce", int'(sys_ce), 1);
    chk("R2 reset div_clk", int'(div_clk), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 post-reset readback", int'(rd_data), 'h0F);
    chk("R6 default undivided", int'(sys_ce), 1);
    prev_n = 1;

    for (int b = 1; b >= 0; b--) begin
      for (int e = 0; e < 2; e++) begin
        for (int f = 0; f < 16; f++) begin
          // here sys_ce is high: this rising edge ends a period
          wr_data = {e[0], f[0], f[3:0]};
          wr_en   = 1'b1;
          @(negedge clk);
          wr_en   = 1'b0;
          src_ref = b[0];
          #1;
          if (f == 0)                 tag = "R3";
          else if (b == 0 && f < 3)   tag = "R4";
          else if (b == 1 && f < 3)   tag = "R5";
          else                        tag = "R10";
          chk($sformatf("%s/R7 readback b=%0d e=%0d f=%0d", tag, b, e, f),
              int'(rd_data), (e << 5) | eff_val(b[0], f));
          measure(n, hi);
          chk($sformatf("R9 old period kept b=%0d e=%0d f=%0d", b, e, f), n, prev_n);
          @(negedge clk);
          measure(n, hi);
          if (b == 1 && e == 0) tag = "R6";
          else if (b == 0)      tag = "R7";
          else                  tag = "R1";
          chk($sformatf("%s period b=%0d e=%0d f=%0d", tag, b, e, f), n, period(b[0], e[0], f));
          chk($sformatf("R8 high cycles b=%0d e=%0d f=%0d", b, e, f), hi,
              (b == 1 && e == 0) ? 0 : period(b[0], e[0], f) / 2);
          prev_n = period(b[0], e[0], f);
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule